// File: doc/BRIEF.md
# Frame-Synchronized Stream Control Gate

This block sits inline in a packetized video stream and holds back image frames until software allows them to proceed. Every packet carries a four-bit type code in the low nibble of its first beat. Packets whose type is not image data go straight through, whatever the software has set. When an image packet's first beat reaches the head of the block's small input buffer, the block reports itself idle. It then waits for the run bit in its register file to be set. Next it copies the pending user control words into shadow registers, reports itself busy and lets the whole frame through unchanged.

Software uses the run and status bits together to change per-frame settings safely. It can clear the run bit, wait for the status bit to fall, rewrite the control words and set the run bit again. A write to a control word while a frame is in flight never reaches the shadow copy that the downstream logic sees during that frame. After reset the block clears its own run bit, so no frame starts from a power-up value.

Top module: `frame_gate`

## Requirements
- R1: Address 0 holds the run bit at bit 0. It can be written and read back once start-up is complete. Addresses 2 and 3 hold user control words that read back what was written.
- R2: Address 1 reads the status bit at bit 0. A bus write to address 1 has no effect on it.
- R3: After reset the run bit reads 0. A write to it during the first few cycles after reset is discarded.
- R4: A packet whose first beat has a type nibble (data bits 3:0) other than 0 is forwarded while the run bit is 0.
- R5: With the run bit at 0, a packet whose first beat has type nibble 0 is not forwarded, and status reads 0 while it waits.
- R6: Once the run bit is 1, the shadow output equals the control words, status reads 1 and the waiting first beat is the next beat forwarded.
- R7: Control words written during a frame do not change the shadow output until the next image packet starts.
- R8: Clearing the run bit during a frame lets that frame finish. The following image packet stalls at its first beat.
- R9: While the block waits, the input accepts exactly two beats (the first beat plus one more) and then holds its ready low.
- R10: Status returns to 0 in the cycle after the image packet's end-of-packet beat is forwarded, and the block goes back to parsing packet headers.
- R11: Output beats (data, start and end markers) are exactly the accepted input beats in order. A stalled output beat holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr, combinational |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | DATA_W | Input beat data; bits 3:0 of a first beat are the packet type |
| in_sop | input | 1 | Input first-beat marker |
| in_eop | input | 1 | Input last-beat marker |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output beat data |
| out_sop | output | 1 | Output first-beat marker |
| out_eop | output | 1 | Output last-beat marker |
| active_ctrl | output | NUM_CTRL*CTRL_W | Shadow copy of the control words used by the current frame |

## Verification
The assertions assume well-formed packets: every packet opens with a beat that has the start marker set and closes with one that has the end marker set, and a stalled input beat is held until it is accepted. The bench keeps to this. It also never writes a control word in the same cycle that a waiting image header is released, so the shadow copy the bench expects at that moment is unambiguous. Downstream backpressure comes from a pseudo-random pattern, which lets stalled output beats and frame ends fall on varied cycles.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int BUS_W     = 32;
  localparam int TYPE_W    = 4;
  localparam logic [TYPE_W-1:0] IMG_TYPE = 4'h0;
  localparam int RUN_ADDR  = 0;
  localparam int STAT_ADDR = 1;
  localparam int CTRL_BASE = 2;

  typedef enum logic [1:0] {
    ST_HDR   = 2'd0,
    ST_PASS  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FRAME = 2'd3
  } fg_state_e;
endpackage

// File: rtl/fg_regfile.sv
module fg_regfile
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_W    = 16,
  parameter int NUM_CTRL  = 2,
  parameter int CLR_DELAY = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csr_wr,
  input  logic [ADDR_W-1:0]          csr_addr,
  input  logic [BUS_W-1:0]           csr_wdata,
  output logic [BUS_W-1:0]           csr_rdata,
  input  logic                       status,
  output logic                       run,
  output logic                       init_done,
  output logic [NUM_CTRL*CTRL_W-1:0] pend
);
  localparam int CNT_W = $clog2(CLR_DELAY + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              run_q, run_d;
  logic [CTRL_W-1:0] ctrl_q [NUM_CTRL];
  logic              unused_wbits;

  assign unused_wbits = ^csr_wdata;

  // start-up counter: the run bit is forced clear until it expires
  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == CNT_W'(CLR_DELAY - 1)) done_d = 1'b1;
      else                                 cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // run bit has no reset of its own; the block clears it after reset
  always_comb begin
    run_d = run_q;
    if (!done_q)
      run_d = 1'b0;
    else if (csr_wr && (csr_addr == ADDR_W'(RUN_ADDR)))
      run_d = csr_wdata[0];
  end

  always_ff @(posedge clk) begin
    run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRL; i++) ctrl_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (csr_wr && (csr_addr == ADDR_W'(CTRL_BASE + i)))
          ctrl_q[i] <= csr_wdata[CTRL_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_pend
      assign pend[g*CTRL_W +: CTRL_W] = ctrl_q[g];
    end
  endgenerate

  assign run       = run_q & done_q;
  assign init_done = done_q;

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == ADDR_W'(RUN_ADDR))
      csr_rdata[0] = run;
    else if (csr_addr == ADDR_W'(STAT_ADDR))
      csr_rdata[0] = status;
    else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (csr_addr == ADDR_W'(CTRL_BASE + i))
          csr_rdata[CTRL_W-1:0] = ctrl_q[i];
    end
  end
endmodule

// File: rtl/fg_skid.sv
module fg_skid #(
  parameter int W     = 26,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [W-1:0]                 in_word,
  output logic                         in_ready,
  input  logic                         pop,
  output logic                         head_valid,
  output logic [W-1:0]                 head_word,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push, do_pop;

  assign in_ready   = (cnt_q != CNT_W'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign push       = in_valid && in_ready;
  assign do_pop     = pop && head_valid;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push)   wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
    if (do_pop) rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
    case ({push, do_pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= in_word;
  end

  assign head_word = mem[rp_q];
  assign fill      = cnt_q;
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic              head_sop,
  input  logic              head_eop,
  input  logic [DATA_W-1:0] head_data,
  input  logic              out_ready,
  input  logic              run,
  input  logic [SHW-1:0]    pend,
  output logic              pop,
  output logic              out_valid,
  output logic              status,
  output logic [SHW-1:0]    shadow,
  output fg_state_e         state
);
  fg_state_e      st_q, st_d;
  logic           stat_q, stat_d;
  logic [SHW-1:0] sh_q;
  logic           img_hdr, xfer, load;

  assign img_hdr = head_valid && head_sop && (head_data[TYPE_W-1:0] == IMG_TYPE);

  always_comb begin
    out_valid = 1'b0;
    case (st_q)
      ST_HDR:   out_valid = head_valid && !img_hdr;
      ST_PASS:  out_valid = head_valid;
      ST_FRAME: out_valid = head_valid;
      default:  out_valid = 1'b0;
    endcase
  end

  assign xfer = out_valid && out_ready;
  assign pop  = xfer;
  assign load = (st_q == ST_WAIT) && run;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HDR: begin
        if (img_hdr)                            st_d = ST_WAIT;
        else if (xfer && head_sop && !head_eop) st_d = ST_PASS;
      end
      ST_PASS:  if (xfer && head_eop) st_d = ST_HDR;
      ST_WAIT:  if (run)              st_d = ST_FRAME;
      ST_FRAME: if (xfer && head_eop) st_d = ST_HDR;
      default:  st_d = ST_HDR;
    endcase
    stat_d = (st_d == ST_FRAME);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      stat_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      if (load) sh_q <= pend;
    end
  end

  assign status = stat_q;
  assign shadow = sh_q;
  assign state  = st_q;
endmodule

// File: rtl/frame_gate.sv
module frame_gate
  import fg_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CTRL_W     = 16,
  parameter int NUM_CTRL   = 2,
  parameter int ADDR_W     = 3,
  parameter int SKID_DEPTH = 2,
  parameter int CLR_DELAY  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csr_wr,
  input  logic [ADDR_W-1:0]          csr_addr,
  input  logic [31:0]                csr_wdata,
  output logic [31:0]                csr_rdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_sop,
  input  logic                       in_eop,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_sop,
  output logic                       out_eop,
  output logic [NUM_CTRL*CTRL_W-1:0] active_ctrl
);
  localparam int SHW    = NUM_CTRL * CTRL_W;
  localparam int WORD_W = DATA_W + 2;
  localparam int FILL_W = $clog2(SKID_DEPTH + 1);

  logic [1:0]        rs_q;
  logic              core_rst_n;
  logic              run_eff, init_done, status, pop, head_valid;
  logic [SHW-1:0]    pend;
  logic [WORD_W-1:0] head_word;
  logic [FILL_W-1:0] fill;
  fg_state_e         ctrl_state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  fg_regfile #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .NUM_CTRL(NUM_CTRL), .CLR_DELAY(CLR_DELAY)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .status(status),
    .run(run_eff), .init_done(init_done), .pend(pend)
  );

  fg_skid #(.W(WORD_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst_n(core_rst_n), .in_valid(in_valid),
    .in_word({in_sop, in_eop, in_data}), .in_ready(in_ready), .pop(pop),
    .head_valid(head_valid), .head_word(head_word), .fill(fill)
  );

  fg_ctrl #(.DATA_W(DATA_W), .SHW(SHW)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .head_valid(head_valid),
    .head_sop(head_word[WORD_W-1]), .head_eop(head_word[WORD_W-2]),
    .head_data(head_word[DATA_W-1:0]), .out_ready(out_ready), .run(run_eff),
    .pend(pend), .pop(pop), .out_valid(out_valid), .status(status),
    .shadow(active_ctrl), .state(ctrl_state)
  );

  assign out_sop  = head_word[WORD_W-1];
  assign out_eop  = head_word[WORD_W-2];
  assign out_data = head_word[DATA_W-1:0];
endmodule

// File: rtl/fg_checker.sv
module fg_checker
  import fg_pkg::*;
#(
  parameter int SHW    = 32,
  parameter int FILL_W = 2,
  parameter int DEPTH  = 2,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input fg_state_e         state,
  input logic              status,
  input logic              init_done,
  input logic              run_eff,
  input logic [SHW-1:0]    shadow,
  input logic [FILL_W-1:0] fill,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic              out_eop,
  input logic [DATA_W-1:0] out_data
);
  assert_run_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !run_eff);

  assert_wait_no_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !out_valid);

  assert_start_on_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> (out_valid && out_sop && (out_data[TYPE_W-1:0] == IMG_TYPE)));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WAIT) |=> $stable(shadow));

  assert_skid_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(DEPTH)) |-> !in_ready);

  assert_skid_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));

  assert_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME && out_valid && out_ready && out_eop) |=> !status);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));
endmodule

bind frame_gate fg_checker #(
  .SHW(SHW), .FILL_W(FILL_W), .DEPTH(SKID_DEPTH), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(core_rst_n), .state(ctrl_state), .status(status),
  .init_done(init_done), .run_eff(run_eff), .shadow(active_ctrl), .fill(fill),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
);

// File: tb/sim_frame_gate.sv
`timescale 1ns/1ps
module sim_frame_gate;
  localparam int DW = 24;
  localparam int CW = 16;
  localparam int NC = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          csr_wr;
  logic [AW-1:0] csr_addr;
  logic [31:0]   csr_wdata, csr_rdata;
  logic          in_valid, in_ready, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic          out_valid, out_ready, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [NC*CW-1:0] active_ctrl;

  frame_gate u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .active_ctrl(active_ctrl)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [DW+1:0]  exp_q [$];
  logic [CW-1:0]  mctrl [NC];
  logic [NC*CW-1:0] snap;
  bit             in_frame_m = 0;
  int             hdr_xfers = 0;
  int             acc_cnt = 0;
  logic [DW-1:0]  seq = '0;
  logic [15:0]    lf = 16'hACE1;
  bit             slow = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC*CW-1:0] mflat();
    logic [NC*CW-1:0] f;
    for (int i = 0; i < NC; i++) f[i*CW +: CW] = mctrl[i];
    return f;
  endfunction

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready = slow ? lf[0] : 1'b1;
  end

  // reference model, compared every clock
  always @(negedge clk) begin
    bit hv;
    logic [DW+1:0] w;
    if (rst_n) begin
      hv = out_valid && out_sop && (out_data[3:0] == 4'h0);
      if (csr_addr == AW'(1) && !csr_wr)
        chk(csr_rdata[0] == (hv || in_frame_m), "R2 R10 status bit",
            longint'(csr_rdata[0]), longint'(hv || in_frame_m));
      if (in_frame_m)
        chk(active_ctrl == snap, "R7 shadow held in frame",
            longint'(active_ctrl), longint'(snap));
      if (in_valid && in_ready) begin
        exp_q.push_back({in_sop, in_eop, in_data});
        acc_cnt++;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R11 unexpected beat", longint'(out_data), 0);
        else begin
          w = exp_q.pop_front();
          chk(w == {out_sop, out_eop, out_data}, "R11 beat order",
              longint'({out_sop, out_eop, out_data}), longint'(w));
        end
        if (hv) begin
          chk(active_ctrl == mflat(), "R6 shadow loaded at frame start",
              longint'(active_ctrl), longint'(mflat()));
          snap = active_ctrl;
          in_frame_m = !out_eop;
          hdr_xfers++;
        end else if (in_frame_m && out_eop) begin
          in_frame_m = 0;
        end
      end
    end
  end

  task automatic csr_write(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_addr = AW'(a); csr_wdata = d; csr_wr = 1'b1;
    @(posedge clk); #1;
    csr_wr = 1'b0; csr_addr = AW'(1);
    if (a >= 2 && a < 2 + NC) mctrl[a-2] = d[CW-1:0];
  endtask

  task automatic csr_read(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    csr_addr = AW'(a);
    #1;
    d = csr_rdata;
    csr_addr = AW'(1);
  endtask

  task automatic send_pkt(input logic [3:0] typ, input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = (i == 0) ? {seq[DW-5:0], typ} : seq;
      seq++;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int a0, h0;
    for (int i = 0; i < NC; i++) mctrl[i] = '0;
    snap = '0;
    rst_n = 1'b0; csr_wr = 1'b0; csr_addr = AW'(1); csr_wdata = '0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid low", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 reset in_ready high", longint'(in_ready), 1);

    // R3: early write is discarded by the start-up clear
    csr_write(0, 32'h1);
    repeat (12) @(posedge clk);
    csr_read(0, rd);
    chk(rd[0] == 1'b0, "R3 run bit cleared after reset", longint'(rd[0]), 0);
    csr_read(1, rd);
    chk(rd[0] == 1'b0, "R2 status idle after reset", longint'(rd[0]), 0);

    // R1: register access
    csr_write(0, 32'h1);
    csr_read(0, rd);
    chk(rd[0] == 1'b1, "R1 run bit reads back 1", longint'(rd[0]), 1);
    csr_write(0, 32'h0);
    csr_read(0, rd);
    chk(rd[0] == 1'b0, "R1 run bit reads back 0", longint'(rd[0]), 0);
    csr_write(2, 32'h1234);
    csr_write(3, 32'hBEEF);
    csr_read(2, rd);
    chk(rd == 32'h1234, "R1 control word 0 readback", longint'(rd), 32'h1234);
    csr_read(3, rd);
    chk(rd == 32'hBEEF, "R1 control word 1 readback", longint'(rd), 32'hBEEF);

    // R2: write to status has no effect
    csr_write(1, 32'h1);
    csr_read(1, rd);
    chk(rd[0] == 1'b0, "R2 status write ignored", longint'(rd[0]), 0);

    // R4: non-image packets pass with run bit clear
    send_pkt(4'h5, 3);
    send_pkt(4'h9, 1);
    drain();
    chk(exp_q.size() == 0, "R4 non-image packets forwarded", longint'(exp_q.size()), 0);

    // R5, R9, R6: image packet stalls until run set
    a0 = acc_cnt;
    fork
      send_pkt(4'h0, 4);
      begin
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 image header held", longint'(out_valid), 0);
        chk(in_ready == 1'b0, "R9 input ready low when buffer full", longint'(in_ready), 0);
        chk(acc_cnt - a0 == 2, "R9 beats accepted while waiting", longint'(acc_cnt - a0), 2);
        csr_read(1, rd);
        chk(rd[0] == 1'b0, "R5 status 0 while waiting", longint'(rd[0]), 0);
        csr_write(0, 32'h1);
      end
    join
    drain();
    chk(hdr_xfers == 1, "R6 frame released after run set", longint'(hdr_xfers), 1);
    chk(active_ctrl == {16'hBEEF, 16'h1234}, "R6 shadow equals control words",
        longint'(active_ctrl), longint'({16'hBEEF, 16'h1234}));

    // R7: writes during a frame wait for the next frame
    slow = 1;
    fork
      send_pkt(4'h0, 10);
      begin
        while (!in_frame_m) @(posedge clk);
        csr_write(2, 32'h5A5A);
        csr_write(3, 32'h0F0F);
        @(negedge clk);
        chk(active_ctrl == {16'hBEEF, 16'h1234}, "R7 shadow unchanged mid-frame",
            longint'(active_ctrl), longint'({16'hBEEF, 16'h1234}));
      end
    join
    drain();
    send_pkt(4'h0, 2);
    drain();
    chk(active_ctrl == {16'h0F0F, 16'h5A5A}, "R7 new words at next frame",
        longint'(active_ctrl), longint'({16'h0F0F, 16'h5A5A}));

    // R8: clearing run mid-frame
    h0 = hdr_xfers;
    fork
      send_pkt(4'h0, 8);
      begin
        while (hdr_xfers == h0) @(posedge clk);
        csr_write(0, 32'h0);
      end
    join
    drain();
    chk(exp_q.size() == 0, "R8 frame completes after run cleared", longint'(exp_q.size()), 0);
    // R10: back to header parsing, non-image still flows
    send_pkt(4'h3, 2);
    drain();
    chk(exp_q.size() == 0, "R10 header parse resumed", longint'(exp_q.size()), 0);
    h0 = hdr_xfers;
    fork
      send_pkt(4'h0, 3);
      begin
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 next image frame stalls", longint'(out_valid), 0);
        chk(hdr_xfers == h0, "R8 no header forwarded", longint'(hdr_xfers), longint'(h0));
        csr_write(0, 32'h1);
      end
    join
    drain();
    chk(hdr_xfers == h0 + 1, "R8 frame released again", longint'(hdr_xfers), longint'(h0 + 1));

    // mixed traffic with backpressure
    for (int k = 0; k < 24; k++) begin
      send_pkt((k % 3 == 0) ? 4'h0 : 4'(k % 5 + 1), 1 + (k % 4));
    end
    drain();
    chk(exp_q.size() == 0, "R11 mixed traffic drained", longint'(exp_q.size()), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule